// File: doc/BRIEF.md
# Depth-Aware Split-Access Color Register Bank

This block holds four 32-bit drawing-engine registers: background color, foreground color, write mask and read mask. A host reaches them through one access port that carries a byte-length qualifier. A 4-byte write always loads the whole register. A narrower access is shaped by the current pixel depth. At 8 and 16 bits per pixel it moves only the low byte or the low half-word. At 32 bits per pixel it either moves the full word, when a wide-transfer mode bit is set, or moves one 16-bit half. In that last case a shared half-select toggle picks the half and flips on every narrow access.

The pixel depth and the screen width both come from a system control value written through its own port. The block decodes that value into a depth code and a width in pixels for the rest of the drawing engine. A separate control port loads the wide-transfer bit and the half-select toggle. Both bits are visible as outputs so software and neighbours can track which half comes next.

Read data is registered. It appears one cycle after the read is performed, zero-extended to 32 bits. A write always has priority over a read in the same cycle. The read is then held and performed in the next cycle, so the toggle changes at most once per clock.

Top module: `color_split_regs`

## Requirements
- R1: After reset, all four registers read as zero, `depth_o` is 0 (8 bpp), `width_o` is 1024, and `half_o` and `wide_o` are 0.
- R2: On a system control write, `sc_depth_code` 2'b00 sets `depth_o` to 0 (8 bpp), 2'b01 sets 1 (16 bpp) and 2'b11 sets 2 (32 bpp). Code 2'b10 leaves the previous depth unchanged.
- R3: `sc_width_code` is {bit7, bit6, bit0} of the control byte. 3'b000 gives 1024, 3'b001 gives 1152, 3'b010 gives 640, 3'b100 gives 800 and 3'b110 gives 1280. Every other code gives 1024.
- R4: At 8 bpp, a narrow write (`acc_len` not 4) stores the low 8 data bits and clears the rest. A read returns the low 8 bits with bits 31:8 zero.
- R5: At 16 bpp, a narrow write stores the low 16 bits and clears the rest. A read returns the low 16 bits with bits 31:16 zero, and the toggle is unchanged.
- R6: At 32 bpp with `wide_o` set, narrow writes and reads move the full 32-bit value, and `half_o` does not change.
- R7: At 32 bpp with `wide_o` clear, a narrow write stores data bits 15:0 into the upper half when `half_o` is 1, or into the lower half when it is 0. The other half is kept, and `half_o` inverts after the write.
- R8: At 32 bpp with `wide_o` clear, a read first inverts `half_o`. It then returns the lower half if the new value is 1, or the upper half if the new value is 0, in bits 15:0.
- R9: A write with `acc_len` equal to 4 loads all 32 bits at any depth and leaves `half_o` unchanged.
- R10: `acc_rvalid` rises one cycle after a read strobe that has no write beside it. When a write and a read strobe share a cycle, the write is applied first and the read is performed in the next cycle, so its data reflects the write and is valid two cycles after the strobe.
- R11: A control write loads `wide_o` from `ctl_wide_d` and `half_o` from `ctl_half_d`. In the same cycle it overrides any toggle flip an access would cause, although that access still uses the old toggle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc_we | input | 1 | System control write strobe |
| sc_depth_code | input | 2 | Pixel depth field of the control byte |
| sc_width_code | input | 3 | Screen width field {bit7, bit6, bit0} |
| ctl_we | input | 1 | Control write strobe |
| ctl_wide_d | input | 1 | New wide-transfer mode bit |
| ctl_half_d | input | 1 | New half-select toggle value |
| acc_we | input | 1 | Register write strobe |
| acc_re | input | 1 | Register read strobe |
| acc_sel | input | 2 | Register select: 0 background, 1 foreground, 2 write mask, 3 read mask |
| acc_len | input | 3 | Access length in bytes; 4 means full-word write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data, unused bits zero |
| acc_rvalid | output | 1 | Read data valid |
| depth_o | output | 2 | Decoded depth: 0 = 8 bpp, 1 = 16 bpp, 2 = 32 bpp |
| width_o | output | 11 | Decoded screen width in pixels |
| half_o | output | 1 | Half-select toggle |
| wide_o | output | 1 | Wide-transfer mode bit |

## Verification
The bench builds the block with its defaults: four registers of 32 bits and an 11-bit width output. This brings every register select and the full 1280-pixel width within reach. With a 32-bit word, the halves are 16 bits, so the split path can be checked with values whose two halves differ. That shows exactly which half a narrow write or read touched and whether the untouched half survived. The chosen values exercise a write and a read in the same cycle, a control write in the same cycle as a narrow access, the reserved depth code and the width codes that fall back to 1024.

// File: rtl/cspl_pkg.sv
// Package: shared types and constants for the split-access color register bank.
// Assumes: depth codes 0/1/2 are the encoding seen on depth_o by neighbours.
package cspl_pkg;

    typedef enum logic [1:0] {
        DEPTH_8  = 2'd0,
        DEPTH_16 = 2'd1,
        DEPTH_32 = 2'd2
    } depth_e;

    // Byte length that marks a full-word write.
    localparam int unsigned FULL_LEN = 4;

    // Width of one narrow byte lane.
    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/cspl_mode_dec.sv
// Module: holds the depth and width fields of the system control value and
// decodes them for the drawing engine.
// Assumes: the reserved depth code keeps the previous depth; unknown width
// codes fall back to 1024 pixels.
module cspl_mode_dec
    import cspl_pkg::*;
#(
    parameter int WIDTH_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sc_we,
    input  logic [1:0]         sc_depth_code,
    input  logic [2:0]         sc_width_code,
    output depth_e             depth_o,
    output logic [WIDTH_W-1:0] width_o
);

    depth_e     depth_q;
    logic [2:0] wcode_q;

    // Capture the depth on a control write; the reserved code keeps the old depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= DEPTH_8;
        end else if (sc_we) begin
            case (sc_depth_code)
                2'b00:   depth_q <= DEPTH_8;
                2'b01:   depth_q <= DEPTH_16;
                2'b11:   depth_q <= DEPTH_32;
                default: depth_q <= depth_q;
            endcase
        end
    end

    // Capture the raw width field on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcode_q <= 3'b000;
        end else if (sc_we) begin
            wcode_q <= sc_width_code;
        end
    end

    // Translate the stored width field into a pixel count.
    always_comb begin
        case (wcode_q)
            3'b000:  width_o = WIDTH_W'(1024);
            3'b001:  width_o = WIDTH_W'(1152);
            3'b010:  width_o = WIDTH_W'(640);
            3'b100:  width_o = WIDTH_W'(800);
            3'b110:  width_o = WIDTH_W'(1280);
            default: width_o = WIDTH_W'(1024);
        endcase
    end

    assign depth_o = depth_q;

endmodule

// File: rtl/cspl_half_ctl.sv
// Module: keeps the wide-transfer bit and the shared half-select toggle.
// Assumes: a narrow write and a performed read never occur in the same cycle
// (the top arbitrates); a control write overrides any access-driven flip.
module cspl_half_ctl
    import cspl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ctl_we,
    input  logic   ctl_wide_d,
    input  logic   ctl_half_d,
    input  depth_e depth,
    input  logic   wr_narrow,
    input  logic   rd_go,
    output logic   wide_o,
    output logic   half_o,
    output logic   split_o,
    output logic   rd_half_o
);

    logic wide_q;
    logic half_q;
    logic flip;

    // Split mode: 32 bpp without the wide-transfer override.
    always_comb begin
        split_o   = (depth == DEPTH_32) && !wide_q;
        flip      = split_o && (wr_narrow || rd_go);
        rd_half_o = split_o ? ~half_q : half_q;
    end

    // Load the mode bit from the control port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
        end else if (ctl_we) begin
            wide_q <= ctl_wide_d;
        end
    end

    // Update the toggle: the control port first, then the access-driven flip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (ctl_we) begin
            half_q <= ctl_half_d;
        end else if (flip) begin
            half_q <= ~half_q;
        end
    end

    assign wide_o = wide_q;
    assign half_o = half_q;

endmodule

// File: rtl/cspl_reg_bank.sv
// Module: the register bank. Each entry merges write data according to
// depth, split mode and the current half-select.
// Assumes: DW is even and at least twice the byte lane width.
module cspl_reg_bank
    import cspl_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int DW    = 32,
    parameter int SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_go,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic                     wr_full,
    input  depth_e                   depth,
    input  logic                     split,
    input  logic                     half,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  regs_o
);

    localparam int HW = DW / 2;
    localparam int BW = LANE_W;

    // Compute the new register value for one write.
    function automatic logic [DW-1:0] merge_word(
        input logic [DW-1:0] old_v,
        input logic [DW-1:0] new_v,
        input depth_e        dep,
        input logic          spl,
        input logic          hsel,
        input logic          full
    );
        logic [DW-1:0] res;
        if (full) begin
            res = new_v;
        end else begin
            case (dep)
                DEPTH_8:  res = {{(DW-BW){1'b0}}, new_v[BW-1:0]};
                DEPTH_16: res = {{(DW-HW){1'b0}}, new_v[HW-1:0]};
                default: begin
                    if (!spl)
                        res = new_v;
                    else if (hsel)
                        res = {new_v[HW-1:0], old_v[HW-1:0]};
                    else
                        res = {old_v[DW-1:HW], new_v[HW-1:0]};
                end
            endcase
        end
        return res;
    endfunction

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] val_q;

        // Store a write addressed to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_go && (wr_sel == SEL_W'(g))) begin
                val_q <= merge_word(val_q, wdata, depth, split, half, wr_full);
            end
        end

        assign regs_o[g] = val_q;
    end

endmodule

// File: rtl/cspl_rd_path.sv
// Module: registered read path that shapes the selected register by depth
// and half-select.
// Assumes: rd_half is the post-flip toggle value supplied by the half control.
module cspl_rd_path
    import cspl_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int DW    = 32,
    parameter int SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_go,
    input  logic [SEL_W-1:0]         rd_sel,
    input  depth_e                   depth,
    input  logic                     split,
    input  logic                     rd_half,
    input  logic [NREG-1:0][DW-1:0]  regs,
    output logic [DW-1:0]            rdata_o,
    output logic                     rvalid_o
);

    localparam int HW = DW / 2;
    localparam int BW = LANE_W;

    logic [DW-1:0] word;
    logic [DW-1:0] shaped;

    // Select the register and keep only the bits this depth exposes.
    always_comb begin
        word = regs[rd_sel];
        case (depth)
            DEPTH_8:  shaped = {{(DW-BW){1'b0}}, word[BW-1:0]};
            DEPTH_16: shaped = {{(DW-HW){1'b0}}, word[HW-1:0]};
            default: begin
                if (!split)
                    shaped = word;
                else if (rd_half)
                    shaped = {{(DW-HW){1'b0}}, word[HW-1:0]};
                else
                    shaped = {{(DW-HW){1'b0}}, word[DW-1:HW]};
            end
        endcase
    end

    // Register the shaped data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_go;
            if (rd_go)
                rdata_o <= shaped;
        end
    end

endmodule

// File: rtl/color_split_regs.sv
// Module: top of the depth-aware split-access color register bank.
// Arbitrates writes over reads, holds one stalled read and wires the mode
// decoder, half control, register bank and read path together.
// Assumes: the host issues no new read strobe while a stalled read waits.
module color_split_regs
    import cspl_pkg::*;
#(
    parameter int NREG    = 4,
    parameter int DW      = 32,
    parameter int WIDTH_W = 11,
    parameter int LEN_W   = 3,
    localparam int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sc_we,
    input  logic [1:0]         sc_depth_code,
    input  logic [2:0]         sc_width_code,
    input  logic               ctl_we,
    input  logic               ctl_wide_d,
    input  logic               ctl_half_d,
    input  logic               acc_we,
    input  logic               acc_re,
    input  logic [SEL_W-1:0]   acc_sel,
    input  logic [LEN_W-1:0]   acc_len,
    input  logic [DW-1:0]      acc_wdata,
    output logic [DW-1:0]      acc_rdata,
    output logic               acc_rvalid,
    output logic [1:0]         depth_o,
    output logic [WIDTH_W-1:0] width_o,
    output logic               half_o,
    output logic               wide_o
);

    depth_e                  depth;
    logic                    split;
    logic                    rd_half;
    logic                    wr_full;
    logic                    wr_narrow;
    logic                    rd_go;
    logic [SEL_W-1:0]        rd_sel;
    logic                    pend_q;
    logic [SEL_W-1:0]        pend_sel_q;
    logic [NREG-1:0][DW-1:0] regs;

    // Classify the access and decide whether a read is performed this cycle.
    always_comb begin
        wr_full   = (acc_len == LEN_W'(FULL_LEN));
        wr_narrow = acc_we && !wr_full;
        rd_go     = (acc_re || pend_q) && !acc_we;
        rd_sel    = pend_q ? pend_sel_q : acc_sel;
    end

    // Hold a read that lost arbitration to a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_sel_q <= '0;
        end else begin
            pend_q <= (acc_re || pend_q) && acc_we;
            if (acc_re && acc_we)
                pend_sel_q <= acc_sel;
        end
    end

    cspl_mode_dec #(
        .WIDTH_W (WIDTH_W)
    ) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .sc_we         (sc_we),
        .sc_depth_code (sc_depth_code),
        .sc_width_code (sc_width_code),
        .depth_o       (depth),
        .width_o       (width_o)
    );

    cspl_half_ctl u_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wide_d (ctl_wide_d),
        .ctl_half_d (ctl_half_d),
        .depth      (depth),
        .wr_narrow  (wr_narrow),
        .rd_go      (rd_go),
        .wide_o     (wide_o),
        .half_o     (half_o),
        .split_o    (split),
        .rd_half_o  (rd_half)
    );

    cspl_reg_bank #(
        .NREG  (NREG),
        .DW    (DW),
        .SEL_W (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (acc_we),
        .wr_sel  (acc_sel),
        .wr_full (wr_full),
        .depth   (depth),
        .split   (split),
        .half    (half_o),
        .wdata   (acc_wdata),
        .regs_o  (regs)
    );

    cspl_rd_path #(
        .NREG  (NREG),
        .DW    (DW),
        .SEL_W (SEL_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .rd_sel   (rd_sel),
        .depth    (depth),
        .split    (split),
        .rd_half  (rd_half),
        .regs     (regs),
        .rdata_o  (acc_rdata),
        .rvalid_o (acc_rvalid)
    );

    assign depth_o = depth;

endmodule

// File: rtl/color_split_regs_chk.sv
// Module: property checker for color_split_regs, attached by bind.
// Assumes: the top's default 8-bit lane and DW-bit data.
module color_split_regs_chk #(
    parameter int DW      = 32,
    parameter int WIDTH_W = 11,
    parameter int LEN_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_we,
    input logic               acc_we,
    input logic               acc_re,
    input logic [LEN_W-1:0]   acc_len,
    input logic [DW-1:0]      acc_rdata,
    input logic               acc_rvalid,
    input logic [1:0]         depth_o,
    input logic [WIDTH_W-1:0] width_o,
    input logic               half_o,
    input logic               wide_o
);

    AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o != 2'b11); // R2

    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (width_o == WIDTH_W'(640)) || (width_o == WIDTH_W'(800)) ||
        (width_o == WIDTH_W'(1024)) || (width_o == WIDTH_W'(1152)) ||
        (width_o == WIDTH_W'(1280))); // R3

    AST_NARROW8_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rvalid && ($past(depth_o) == 2'd0)) |-> (acc_rdata[DW-1:8] == '0)); // R4

    AST_NARROW16_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rvalid && ($past(depth_o) == 2'd1)) |-> (acc_rdata[DW-1:DW/2] == '0)); // R5

    AST_SPLIT_WRITE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && (acc_len != LEN_W'(4)) && !ctl_we && (depth_o == 2'd2) && !wide_o)
        |=> (half_o != $past(half_o))); // R7

    AST_FULL_KEEPS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && (acc_len == LEN_W'(4)) && !ctl_we) |=> $stable(half_o)); // R9

    AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_re && !acc_we) |=> acc_rvalid); // R10

    AST_WRITE_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> !acc_rvalid); // R10

    AST_STALLED_READ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_we && $past(acc_we && acc_re)) |=> acc_rvalid); // R10

endmodule

bind color_split_regs color_split_regs_chk #(
    .DW      (DW),
    .WIDTH_W (WIDTH_W),
    .LEN_W   (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .acc_we     (acc_we),
    .acc_re     (acc_re),
    .acc_len    (acc_len),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid),
    .depth_o    (depth_o),
    .width_o    (width_o),
    .half_o     (half_o),
    .wide_o     (wide_o)
);

// File: tb/color_split_regs_tb.sv
// Directed bench for color_split_regs: one task per scenario.
module color_split_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sc_we = 1'b0;
    logic [1:0]  sc_depth_code = '0;
    logic [2:0]  sc_width_code = '0;
    logic        ctl_we = 1'b0;
    logic        ctl_wide_d = 1'b0;
    logic        ctl_half_d = 1'b0;
    logic        acc_we = 1'b0;
    logic        acc_re = 1'b0;
    logic [1:0]  acc_sel = '0;
    logic [2:0]  acc_len = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_rvalid;
    logic [1:0]  depth_o;
    logic [10:0] width_o;
    logic        half_o;
    logic        wide_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    color_split_regs u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sc_we         (sc_we),
        .sc_depth_code (sc_depth_code),
        .sc_width_code (sc_width_code),
        .ctl_we        (ctl_we),
        .ctl_wide_d    (ctl_wide_d),
        .ctl_half_d    (ctl_half_d),
        .acc_we        (acc_we),
        .acc_re        (acc_re),
        .acc_sel       (acc_sel),
        .acc_len       (acc_len),
        .acc_wdata     (acc_wdata),
        .acc_rdata     (acc_rdata),
        .acc_rvalid    (acc_rvalid),
        .depth_o       (depth_o),
        .width_o       (width_o),
        .half_o        (half_o),
        .wide_o        (wide_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sc_write(input logic [1:0] dcode, input logic [2:0] wcode);
        @(negedge clk);
        sc_we = 1'b1; sc_depth_code = dcode; sc_width_code = wcode;
        @(negedge clk);
        sc_we = 1'b0;
    endtask

    task automatic ctl_write(input logic wide, input logic half);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wide_d = wide; ctl_half_d = half;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [2:0] len, input logic [31:0] d);
        @(negedge clk);
        acc_we = 1'b1; acc_sel = sel; acc_len = len; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [31:0] d, output logic v);
        @(negedge clk);
        acc_re = 1'b1; acc_sel = sel;
        @(negedge clk);
        acc_re = 1'b0;
        d = acc_rdata; v = acc_rvalid;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic v;
        chk("R1 depth", 32'(depth_o), 32'd0);
        chk("R1 width", 32'(width_o), 32'd1024);
        chk("R1 half", 32'(half_o), 32'd0);
        chk("R1 wide", 32'(wide_o), 32'd0);
        for (int i = 0; i < 4; i++) begin
            reg_read(2'(i), d, v);
            chk("R1 reg zero", d, 32'd0);
        end
    endtask

    task automatic t_depth();
        sc_write(2'b01, 3'b000);
        chk("R2 16bpp", 32'(depth_o), 32'd1);
        sc_write(2'b11, 3'b000);
        chk("R2 32bpp", 32'(depth_o), 32'd2);
        sc_write(2'b10, 3'b000);
        chk("R2 reserved keeps", 32'(depth_o), 32'd2);
        sc_write(2'b00, 3'b000);
        chk("R2 8bpp", 32'(depth_o), 32'd0);
    endtask

    task automatic t_width();
        sc_write(2'b00, 3'b010); chk("R3 640", 32'(width_o), 32'd640);
        sc_write(2'b00, 3'b100); chk("R3 800", 32'(width_o), 32'd800);
        sc_write(2'b00, 3'b001); chk("R3 1152", 32'(width_o), 32'd1152);
        sc_write(2'b00, 3'b110); chk("R3 1280", 32'(width_o), 32'd1280);
        sc_write(2'b00, 3'b111); chk("R3 fallback 111", 32'(width_o), 32'd1024);
        sc_write(2'b00, 3'b011); chk("R3 fallback 011", 32'(width_o), 32'd1024);
        sc_write(2'b00, 3'b000); chk("R3 1024", 32'(width_o), 32'd1024);
    endtask

    task automatic t_8bpp();
        logic [31:0] d;
        logic v;
        sc_write(2'b00, 3'b000);
        reg_write(2'd1, 3'd1, 32'hDEADBEEF);
        reg_read(2'd1, d, v);
        chk("R4 read low byte", d, 32'h000000EF);
        chk("R4 rvalid", 32'(v), 32'd1);
        chk("R4 half kept", 32'(half_o), 32'd0);
    endtask

    task automatic t_16bpp();
        logic [31:0] d;
        logic v;
        sc_write(2'b01, 3'b000);
        reg_write(2'd2, 3'd2, 32'h12345678);
        reg_read(2'd2, d, v);
        chk("R5 read low half", d, 32'h00005678);
        chk("R5 half kept", 32'(half_o), 32'd0);
        sc_write(2'b11, 3'b000);
        ctl_write(1'b1, 1'b0);
        reg_read(2'd2, d, v);
        chk("R5 upper cleared", d, 32'h00005678);
    endtask

    task automatic t_32wide();
        logic [31:0] d;
        logic v;
        sc_write(2'b11, 3'b000);
        ctl_write(1'b1, 1'b0);
        reg_write(2'd3, 3'd2, 32'hCAFEF00D);
        chk("R6 half after write", 32'(half_o), 32'd0);
        reg_read(2'd3, d, v);
        chk("R6 full read", d, 32'hCAFEF00D);
        chk("R6 half after read", 32'(half_o), 32'd0);
    endtask

    task automatic t_32split();
        logic [31:0] d;
        logic v;
        sc_write(2'b11, 3'b000);
        ctl_write(1'b0, 1'b0);
        reg_write(2'd0, 3'd4, 32'h11112222);
        chk("R9 half after full", 32'(half_o), 32'd0);
        reg_write(2'd0, 3'd2, 32'h0000AAAA);
        chk("R7 flip after low write", 32'(half_o), 32'd1);
        reg_write(2'd0, 3'd2, 32'h0000BBBB);
        chk("R7 flip after high write", 32'(half_o), 32'd0);
        reg_read(2'd0, d, v);
        chk("R8 first read low", d, 32'h0000AAAA);
        chk("R8 flip on read", 32'(half_o), 32'd1);
        reg_read(2'd0, d, v);
        chk("R8 second read high", d, 32'h0000BBBB);
        ctl_write(1'b1, 1'b0);
        reg_read(2'd0, d, v);
        chk("R7 halves merged", d, 32'hBBBBAAAA);
    endtask

    task automatic t_full_any_depth();
        logic [31:0] d;
        logic v;
        sc_write(2'b00, 3'b000);
        reg_write(2'd1, 3'd4, 32'h89ABCDEF);
        reg_read(2'd1, d, v);
        chk("R9 8bpp view", d, 32'h000000EF);
        sc_write(2'b11, 3'b000);
        ctl_write(1'b1, 1'b0);
        reg_read(2'd1, d, v);
        chk("R9 full word kept", d, 32'h89ABCDEF);
    endtask

    task automatic t_ctl();
        logic [31:0] d;
        logic v;
        ctl_write(1'b0, 1'b1);
        chk("R11 half load", 32'(half_o), 32'd1);
        chk("R11 wide load", 32'(wide_o), 32'd0);
        ctl_write(1'b1, 1'b1);
        chk("R11 wide set", 32'(wide_o), 32'd1);
        sc_write(2'b11, 3'b000);
        ctl_write(1'b0, 1'b0);
        reg_write(2'd1, 3'd4, 32'h00000000);
        @(negedge clk);
        acc_we = 1'b1; acc_sel = 2'd1; acc_len = 3'd2; acc_wdata = 32'h00001234;
        ctl_we = 1'b1; ctl_wide_d = 1'b0; ctl_half_d = 1'b1;
        @(negedge clk);
        acc_we = 1'b0; ctl_we = 1'b0;
        chk("R11 control beats flip", 32'(half_o), 32'd1);
        reg_read(2'd1, d, v);
        chk("R11 write used old half", d, 32'h00000000);
        reg_read(2'd1, d, v);
        chk("R11 low half written", d, 32'h00001234);
    endtask

    task automatic t_conflict();
        sc_write(2'b11, 3'b000);
        ctl_write(1'b1, 1'b0);
        @(negedge clk);
        acc_we = 1'b1; acc_re = 1'b1; acc_sel = 2'd2; acc_len = 3'd4; acc_wdata = 32'h55556666;
        @(negedge clk);
        acc_we = 1'b0; acc_re = 1'b0;
        chk("R10 no valid while stalled", 32'(acc_rvalid), 32'd0);
        @(negedge clk);
        chk("R10 stalled valid", 32'(acc_rvalid), 32'd1);
        chk("R10 read sees write", acc_rdata, 32'h55556666);
        @(negedge clk);
        chk("R10 valid drops", 32'(acc_rvalid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_depth();
        t_width();
        t_8bpp();
        t_16bpp();
        t_32wide();
        t_32split();
        t_full_any_depth();
        t_ctl();
        t_conflict();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule